// File: doc/BRIEF.md
# Bit-Serial Four-Term Weighted Sum

This block forms the weighted sum y = C0·x0 + C1·x1 + C2·x2 + C3·x3 without a multiplier. The four weights are fixed when the block is built. The four inputs are signed two's-complement words.

A start strobe copies all four input words into per-lane shift registers and clears a running sum. The block then consumes one bit position per clock, beginning with the least significant bit. The current bit of every lane, together with a flag that is high only while the sign bits are consumed, selects an entry of a constant table. Each entry holds the sum of the weights whose lane bit is set, negated when the flag is high. Every cycle the running sum is halved and the selected entry, scaled to the top of the word, is added to it.

After N bit cycles the running sum equals the exact weighted sum, and a one-cycle valid pulse marks it. The result then stays unchanged until the next accepted start.

Top module: `da_dot4`

## Requirements
- R1: After a computation, `result` equals the exact sum of Ck·xk. Each xk is the signed N-bit word in `x_in[k*N +: N]` and each Ck is the signed CW-bit weight in `COEFS[k*CW +: CW]`. The result is RES_W = N+CW+clog2(K) bits wide and loses no precision.
- R2: When `start` is sampled high while idle, `valid` goes high on the N-th rising edge after that edge.
- R3: `valid` is high for exactly one cycle per computation.
- R4: A `start` pulse that arrives while a computation is running has no effect. Neither the inputs in use nor the timing of the running computation change.
- R5: While `rst_n` is low at a rising edge, `valid` is cleared and `result` is cleared to 0.
- R6: Table selection works per lane. The table address is {sign-time flag, bit of lane 3, lane 2, lane 1, lane 0}. When the flag is 0 the entry is the sum of the weights whose lane bit is 1 (address 00000 gives 0, 01111 gives C0+C1+C2+C3). When the flag is 1 the entry is the negated sum. An input of 1 in lane k alone therefore yields Ck.
- R7: Bits are consumed least significant first, and the last bit is treated as the sign with weight −2^(N−1). The most negative input (−2^(N−1)) in lane k yields −2^(N−1)·Ck, and an input of −1 yields −Ck.
- R8: While idle, `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the inputs and begin a computation; ignored while busy |
| x_in | input | K*N | Four signed input words, lane k at bits [k*N +: N] |
| result | output | N+CW+clog2(K) | Signed weighted sum |
| valid | output | 1 | One-cycle pulse when `result` is final |

## Verification
Single-lane inputs of 1 isolate each table weight and the lane-to-address mapping. An all-ones input exercises the full subset sum. Inputs of −1 and the most negative value test the negated sign-time entries and the sign weighting on the last bit: swapping the shift direction or dropping the negation makes them fail, while positive-only patterns would not notice. Mixed-sign table vectors and a few hundred random words check the alignment and full precision of the halving accumulator. A start pulse issued mid-computation with different inputs shows whether a reload or restart leaks through.

// File: rtl/da_pkg.sv
// Package: shared types for the bit-serial weighted-sum block.
package da_pkg;
    // Sequencer state: waiting for start, or consuming bit positions.
    typedef enum logic [0:0] {
        DA_IDLE = 1'b0,
        DA_RUN  = 1'b1
    } da_state_e;
endpackage

// File: rtl/da_ctrl.sv
// Module: da_ctrl
// Sequences one computation. It accepts start only when idle, counts N bit
// cycles, raises the sign-time flag in the last one, and pulses valid one
// cycle later. Assumes N >= 2.
module da_ctrl #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic run,
    output logic sign_time,
    output logic valid
);
    import da_pkg::*;

    localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

    da_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    // Decode the phase outputs from state and counter.
    always_comb begin
        run       = (state_q == DA_RUN);
        load      = start && (state_q == DA_IDLE);
        sign_time = run && (cnt_q == LAST);
    end

    // Advance the state, the bit counter and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DA_IDLE;
            cnt_q   <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state_q)
                DA_IDLE: begin
                    if (start) begin
                        state_q <= DA_RUN;
                        cnt_q   <= '0;
                    end
                end
                DA_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= DA_IDLE;
                        valid   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= DA_IDLE;
            endcase
        end
    end

    // R3: valid never lasts two cycles
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R2: valid follows the sign-time cycle
    p_valid_after_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sign_time |=> valid);
    // R2: no result is flagged while bits are still being consumed
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !run);
    // R4: a start during a run does not restart the counter
    p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && !sign_time) |=> (run && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/da_shreg.sv
// Module: da_shreg
// One right-shifting register per lane. It captures the lane words on load
// and presents the current least significant bit of every lane as the
// bit-slice. Assumes load and shift are never high together.
module da_shreg #(
    parameter int K = 4,
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           shift,
    input  logic [K*N-1:0] x_in,
    output logic [K-1:0]   slice
);
    for (genvar k = 0; k < K; k++) begin : g_lane
        logic [N-1:0] lane_q;

        // Capture the lane word on load, else move toward the LSB.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (load)
                lane_q <= x_in[k*N +: N];
            else if (shift)
                lane_q <= lane_q >> 1;
        end

        assign slice[k] = lane_q[0];

        // R7: the whole lane word is captured on load
        p_lane_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (lane_q == $past(x_in[k*N +: N])));
    end
endmodule

// File: rtl/da_lut.sv
// Module: da_lut
// Constant table of weight subset sums with 2^(K+1) entries, computed at
// elaboration from COEFS. The top address bit selects the negated form.
// Assumes LW is wide enough for +/- K times the largest weight.
module da_lut #(
    parameter int             K     = 4,
    parameter int             CW    = 8,
    parameter int             LW    = 11,
    parameter logic [K*CW-1:0] COEFS = '0
) (
    input  logic [K:0]           addr,
    output logic signed [LW-1:0] value
);
    localparam int ENTRIES = 2 ** (K + 1);

    // Subset sum for one address; negated when the sign-time bit is set.
    function automatic logic signed [LW-1:0] entry_of(input int a);
        logic signed [LW-1:0] s;
        s = '0;
        for (int k = 0; k < K; k++)
            if (a[k]) s = s + LW'($signed(COEFS[k*CW +: CW]));
        if (a[K]) s = -s;
        return s;
    endfunction

    logic signed [LW-1:0] table_w [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign table_w[e] = entry_of(e);
    end

    // Select the entry for the current bit-slice.
    always_comb value = table_w[addr];
endmodule

// File: rtl/da_acc.sv
// Module: da_acc
// Scaling accumulator. On each run cycle it halves the running sum
// (arithmetic shift) and adds the table value aligned N-1 places up, so the
// result after N cycles is exact. Clear zeroes it. Assumes RW >= N+LW-1.
module da_acc #(
    parameter int N  = 8,
    parameter int LW = 11,
    parameter int RW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 run,
    input  logic signed [LW-1:0] lut_val,
    output logic signed [RW-1:0] acc
);
    logic signed [RW-1:0] lut_ext;

    // Sign-extend the table value to the accumulator width.
    always_comb lut_ext = {{(RW-LW){lut_val[LW-1]}}, lut_val};

    // Clear on load, halve and add while running, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clear)
            acc <= '0;
        else if (run)
            acc <= (acc >>> 1) + (lut_ext <<< (N - 1));
    end

    // R5: a clear empties the sum
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));
    // R8: the sum holds while idle
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !run) |=> $stable(acc));
endmodule

// File: rtl/da_dot4.sv
// Module: da_dot4
// Bit-serial weighted sum of K signed lanes with fixed weights, built from
// a table of subset sums and a halving accumulator. A computation takes N
// cycles after start; valid then pulses once. Assumes N >= 2.
module da_dot4 #(
    parameter int              K     = 4,
    parameter int              N     = 8,
    parameter int              CW    = 8,
    parameter logic [K*CW-1:0] COEFS = {8'h80, 8'h19, 8'hF9, 8'h03},
    localparam int             RES_W = N + CW + $clog2(K)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [K*N-1:0]          x_in,
    output logic signed [RES_W-1:0] result,
    output logic                    valid
);
    localparam int LUT_W = CW + $clog2(K) + 1;

    logic                    load;
    logic                    run;
    logic                    sign_time;
    logic [K-1:0]            slice;
    logic signed [LUT_W-1:0] lut_val;

    da_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .run       (run),
        .sign_time (sign_time),
        .valid     (valid)
    );

    da_shreg #(.K(K), .N(N)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (run),
        .x_in  (x_in),
        .slice (slice)
    );

    da_lut #(.K(K), .CW(CW), .LW(LUT_W), .COEFS(COEFS)) u_lut (
        .addr  ({sign_time, slice}),
        .value (lut_val)
    );

    da_acc #(.N(N), .LW(LUT_W), .RW(RES_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .run     (run),
        .lut_val (lut_val),
        .acc     (result)
    );

    // R4: a load only happens when no computation is running
    p_load_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !run);
endmodule

// File: tb/da_dot4_test.sv
// Bench for da_dot4: a stimulus table, then random words, then directed
// checks for reset, timing, ignored start and hold.
module da_dot4_test;
    localparam int CLK_PERIOD = 10;
    localparam int K     = 4;
    localparam int N     = 8;
    localparam int CW    = 8;
    localparam int RES_W = N + CW + 2;
    localparam int WATCHDOG = 150000;
    localparam int COEF [4] = '{3, -7, 25, -128};
    localparam int NVEC = 8;
    localparam int VEC [NVEC][4] = '{
        '{1, 0, 0, 0},
        '{0, 1, 0, 0},
        '{0, 0, 1, 0},
        '{0, 0, 0, 1},
        '{1, 1, 1, 1},
        '{-1, -1, -1, -1},
        '{-128, -128, -128, -128},
        '{127, -128, 127, -128}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [K*N-1:0]          x_in = '0;
    logic signed [RES_W-1:0] result;
    logic                    valid;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    da_dot4 uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .x_in   (x_in),
        .result (result),
        .valid  (valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cycles++;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_sum(input int xs[4]);
        longint s = 0;
        for (int k = 0; k < K; k++) s += longint'(COEF[k]) * longint'(xs[k]);
        return s;
    endfunction

    task automatic drive(input int xs[4]);
        for (int k = 0; k < K; k++) x_in[k*N +: N] = xs[k][N-1:0];
    endtask

    // One full computation: checks latency, value and single-cycle valid.
    task automatic run_op(input int xs[4], input string req);
        int lat;
        @(negedge clk);
        drive(xs);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 0;
        while (!valid && lat < 40) begin
            @(posedge clk); #1;
            lat++;
        end
        chk(lat == N, "R2 latency", lat, N);
        chk(longint'(result) == ref_sum(xs), req, longint'(result), ref_sum(xs));
        @(posedge clk); #1;
        chk(!valid, "R3 valid one cycle", valid, 0);
    endtask

    initial begin
        while (cycles < WATCHDOG && !finished) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int xs[4];
        int ys[4];
        longint held;
        // R5: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(!valid, "R5 reset valid", valid, 0);
        chk(result == 0, "R5 reset result", longint'(result), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R6 single lanes and full subset, R7 sign cases, R1 mixed
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < K; k++) xs[k] = VEC[v][k];
            run_op(xs, (v < 5) ? "R6 subset sum" : "R7 sign weighting");
        end

        // R7: most negative value alone in each lane
        for (int k = 0; k < K; k++) begin
            for (int j = 0; j < K; j++) xs[j] = (j == k) ? -128 : 0;
            run_op(xs, "R7 most negative lane");
        end

        // R1: random signed words
        for (int t = 0; t < 300; t++) begin
            for (int k = 0; k < K; k++) xs[k] = int'($urandom_range(0, 255)) - 128;
            run_op(xs, "R1 random sum");
        end

        // R4: a second start mid-run with other inputs must be ignored
        xs = '{5, -3, 100, -77};
        ys = '{-128, 127, -128, 127};
        @(negedge clk);
        drive(xs);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        drive(ys);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        begin
            int lat = 4;
            while (!valid && lat < 40) begin
                @(posedge clk); #1;
                lat++;
            end
            chk(lat == N, "R4 timing kept", lat, N);
        end
        chk(longint'(result) == ref_sum(xs), "R4 start ignored",
            longint'(result), ref_sum(xs));

        // R8: result holds while idle
        held = longint'(result);
        repeat (6) @(posedge clk);
        #1;
        chk(longint'(result) == held, "R8 hold", longint'(result), held);
        chk(!valid, "R3 no extra valid", valid, 0);

        // R5: reset mid-run clears state
        xs = '{50, 50, 50, 50};
        @(negedge clk);
        drive(xs);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk(result == 0, "R5 reset mid-run", longint'(result), 0);
        chk(!valid, "R5 reset mid-run valid", valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        xs = '{-2, 9, -1, 3};
        run_op(xs, "R1 after reset");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule